// File: doc/BRIEF.md
# Standby Entry and Wake Controller

This block is the power sequencer for a small microcontroller's deepest low-power state. It watches for a sleep instruction. If that instruction retires while the software has chosen full standby, with the low-speed option off and the timer mode bit clear, the block stops the main oscillator and every core clock. In the same step it floats the I/O ports and pulses a partial reset to the two peripherals that need one. Register and RAM contents are untouched, because the block only gates clocks.

There are two ways out of standby. An interrupt wake restarts the oscillator and then counts a programmable settling period on the restarting clock. When the count ends, the block returns clocks to the chip and raises a per-line interrupt exception request. A reset-pin wake turns the oscillator and the chip clocks on together and holds that state while the pin stays low. When the pin returns high, the block requests reset exception handling. A low reset pin always wins, and it also aborts a settling count that is in progress.

Top module: `stby_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the block is running: `osc_en`=1, `clk_en`=1, `io_hiz`=0, and `periph_prst`, `irq_req` and `rst_req` are all 0.
- R2: A `sleep_exec` cycle while running, with `stby_sel`=1, `lowspd_sel`=0 and `tmode_sel`=0, gives `osc_en`=0, `clk_en`=0 and `io_hiz`=1 on the next cycle.
- R3: A `sleep_exec` cycle with any one of those three conditions false leaves the block running (`osc_en`=1, `clk_en`=1, `io_hiz`=0).
- R4: `io_hiz` is 1 in every cycle where the block is not fully running (standby, settling and reset hold), and 0 while it runs.
- R5: `periph_prst` is high for exactly one cycle, the first cycle of standby.
- R6: A rising edge on `ext_irq[i]` wakes the block from standby into settling (`osc_en`=1, `clk_en`=0) only when `irq_en[i]`=1 and `cpu_mask`=0. An edge on a disabled or masked line stays latched, and the block remains in standby with `osc_en`=0. If the mask is later cleared while an enabled line is pending, the block wakes.
- R7: The settling phase lasts exactly 2^(SETTLE_LOG_MIN+c) cycles for select code c = 0..5, and 2^(SETTLE_LOG_MIN+5) cycles for codes 6 and 7. The code is taken from `settle_sel` in the last standby cycle.
- R8: In the cycle after settling ends, `clk_en`=1 and `io_hiz`=0. In that same cycle, `irq_req` is 1 for exactly one cycle, with bit i set for each enabled line that saw a rising edge since standby was entered, including edges that arrived during settling.
- R9: `rst_pin_n` low (after a two-stage synchronizer) in any state gives `osc_en`=1, `clk_en`=1 and `io_hiz`=1. It aborts any settling count, and no `irq_req` follows.
- R10: When `rst_pin_n` returns high, the block runs again and `rst_req` is 1 for exactly one cycle, the first cycle with `io_hiz`=0. `rst_req` and `irq_req` are never set together.
- R11: When a reset-pin assertion and an interrupt edge reach the block in the same cycle, the reset path wins, and no settling cycle (`osc_en`=1, `clk_en`=0) occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (restarting oscillator clock) |
| rst | input | 1 | Synchronous active-high reset |
| sleep_exec | input | 1 | One-cycle strobe: sleep instruction retired |
| stby_sel | input | 1 | Software selects full standby on sleep |
| lowspd_sel | input | 1 | Low-speed operation selected (blocks standby) |
| tmode_sel | input | 1 | Timer mode bit (blocks standby) |
| settle_sel | input | 3 | Settling-time select code |
| ext_irq | input | N_IRQ | External wake interrupt lines (asynchronous) |
| irq_en | input | N_IRQ | Per-line wake enable |
| cpu_mask | input | 1 | CPU interrupt mask; 1 blocks interrupt wake |
| rst_pin_n | input | 1 | Active-low reset pin (asynchronous) |
| osc_en | output | 1 | Main oscillator enable |
| clk_en | output | 1 | CPU and peripheral clock enable |
| io_hiz | output | 1 | Float all I/O port outputs |
| periph_prst | output | 1 | Partial reset pulse for the timer and serial port |
| irq_req | output | N_IRQ | Interrupt exception request pulse, one bit per line |
| rst_req | output | 1 | Reset exception request pulse |

## Verification
The checker enforces several rules on every cycle. The chip clocks never run without the oscillator, the ports float whenever clocks are stopped, and the partial reset pulse lasts one cycle and coincides with the oscillator stopping. An interrupt request appears only on the rising edge of the clock enable, a reset request appears only when leaving the floating, clocked hold, and the two requests never overlap. Other properties need the bench's scenarios. These are the exact settling length for each select code, latched edges on disabled or masked lines, edges that arrive during settling and join the request, an abort partway through settling, and a reset pin that arrives together with an interrupt.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STANDBY = 2'd1,
    ST_SETTLE  = 2'd2,
    ST_RSTHOLD = 2'd3
  } stby_state_e;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stby_wake_detect.sv
module stby_wake_detect #(
  parameter int N_IRQ = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_s,
  input  logic             capture,
  input  logic             clear,
  output logic [N_IRQ-1:0] hit
);
  logic [N_IRQ-1:0] prev_q;
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] rise;

  assign rise = irq_s & ~prev_q;
  assign hit  = capture ? (pend_q | rise) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_s;
      if (clear)        pend_q <= '0;
      else if (capture) pend_q <= pend_q | rise;
    end
  end
endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
  parameter int SEL_W = 3,
  parameter int LOG_MIN = 13,
  parameter int LOG_SPAN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int LOG_MAX = LOG_MIN + LOG_SPAN;
  localparam int CW = LOG_MAX + 1;

  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    last;

  function automatic logic [CW-1:0] span_of(input logic [SEL_W-1:0] code);
    logic [CW-1:0] one;
    one = CW'(1);
    if (int'(code) > LOG_SPAN) return one << LOG_MAX;
    return one << (LOG_MIN + int'(code));
  endfunction

  assign last = span_of(sel_q) - CW'(1);
  assign done = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) sel_q <= sel;
      cnt_q <= run ? cnt_q + CW'(1) : '0;
    end
  end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
  parameter int N_IRQ = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W = 3,
  parameter int SETTLE_LOG_MIN = 13,
  parameter int SETTLE_LOG_SPAN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_exec,
  input  logic             stby_sel,
  input  logic             lowspd_sel,
  input  logic             tmode_sel,
  input  logic [SEL_W-1:0] settle_sel,
  input  logic [N_IRQ-1:0] ext_irq,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             cpu_mask,
  input  logic             rst_pin_n,
  output logic             osc_en,
  output logic             clk_en,
  output logic             io_hiz,
  output logic             periph_prst,
  output logic [N_IRQ-1:0] irq_req,
  output logic             rst_req
);
  import stby_pkg::*;

  localparam int SW = N_IRQ + 1;

  stby_state_e      state_q, state_d;
  logic [SW-1:0]    raw_in, sync_out;
  logic [N_IRQ-1:0] irq_s, hit;
  logic             pin_s, wake, settle_done, enter_ok;

  assign raw_in = {rst_pin_n, ext_irq};

  stby_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT({1'b1, {N_IRQ{1'b0}}})) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign irq_s = sync_out[N_IRQ-1:0];
  assign pin_s = sync_out[N_IRQ];

  stby_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .clk(clk), .rst(rst), .irq_s(irq_s),
    .capture(state_q == ST_STANDBY || state_q == ST_SETTLE),
    .clear(state_q == ST_RUN || state_q == ST_RSTHOLD),
    .hit(hit)
  );

  stby_settle_timer #(.SEL_W(SEL_W), .LOG_MIN(SETTLE_LOG_MIN), .LOG_SPAN(SETTLE_LOG_SPAN)) u_timer (
    .clk(clk), .rst(rst),
    .load(state_q == ST_STANDBY),
    .run(state_q == ST_SETTLE),
    .sel(settle_sel),
    .done(settle_done)
  );

  assign enter_ok = sleep_exec && stby_sel && !lowspd_sel && !tmode_sel;
  assign wake     = !cpu_mask && (|(hit & irq_en));

  always_comb begin
    state_d = state_q;
    if (!pin_s) begin
      state_d = ST_RSTHOLD;
    end else begin
      case (state_q)
        ST_RUN:     if (enter_ok)    state_d = ST_STANDBY;
        ST_STANDBY: if (wake)        state_d = ST_SETTLE;
        ST_SETTLE:  if (settle_done) state_d = ST_RUN;
        ST_RSTHOLD:                  state_d = ST_RUN;
        default:                     state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      osc_en      <= 1'b1;
      clk_en      <= 1'b1;
      io_hiz      <= 1'b0;
      periph_prst <= 1'b0;
      irq_req     <= '0;
      rst_req     <= 1'b0;
    end else begin
      state_q     <= state_d;
      osc_en      <= (state_d != ST_STANDBY);
      clk_en      <= (state_d == ST_RUN) || (state_d == ST_RSTHOLD);
      io_hiz      <= (state_d != ST_RUN);
      periph_prst <= (state_q == ST_RUN) && (state_d == ST_STANDBY);
      irq_req     <= ((state_q == ST_SETTLE) && (state_d == ST_RUN)) ? (hit & irq_en) : '0;
      rst_req     <= (state_q == ST_RSTHOLD) && (state_d == ST_RUN);
    end
  end
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
  parameter int N_IRQ = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             osc_en,
  input logic             clk_en,
  input logic             io_hiz,
  input logic             periph_prst,
  input logic [N_IRQ-1:0] irq_req,
  input logic             rst_req
);
  // R2: chip clocks never run while the oscillator is stopped
  p_clk_needs_osc_r2: assert property (@(posedge clk) disable iff (rst) clk_en |-> osc_en);

  // R4: ports float whenever clocks are stopped
  p_hiz_when_gated_r4: assert property (@(posedge clk) disable iff (rst) !clk_en |-> io_hiz);

  // R5: partial reset is a single-cycle pulse tied to the oscillator stopping
  p_prst_pulse_r5: assert property (@(posedge clk) disable iff (rst) periph_prst |=> !periph_prst);
  p_prst_on_stop_r5: assert property (@(posedge clk) disable iff (rst) $fell(osc_en) |-> periph_prst);

  // R8: interrupt request only on clock return
  p_irq_on_clk_return_r8: assert property (@(posedge clk) disable iff (rst)
    (|irq_req) |-> ($rose(clk_en) && !io_hiz));
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst) (|irq_req) |=> (irq_req == '0));

  // R10: reset request only when leaving the clocked, floating hold
  p_rstreq_exit_r10: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (!io_hiz && $past(clk_en && io_hiz)));
  p_req_excl_r10: assert property (@(posedge clk) disable iff (rst) !(rst_req && (|irq_req)));
endmodule

bind stby_ctrl stby_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst(rst), .osc_en(osc_en), .clk_en(clk_en), .io_hiz(io_hiz),
  .periph_prst(periph_prst), .irq_req(irq_req), .rst_req(rst_req)
);

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;
  localparam int LOGMIN = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_exec = 1'b0, stby_sel = 1'b1, lowspd_sel = 1'b0, tmode_sel = 1'b0;
  logic [2:0] settle_sel = 3'd0;
  logic [1:0] ext_irq = 2'b00, irq_en = 2'b11;
  logic       cpu_mask = 1'b0, rst_pin_n = 1'b1;
  logic       osc_en, clk_en, io_hiz, periph_prst, rst_req;
  logic [1:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stby_ctrl #(.N_IRQ(2), .SYNC_STAGES(2), .SEL_W(3), .SETTLE_LOG_MIN(LOGMIN), .SETTLE_LOG_SPAN(5)) uut (
    .clk(clk), .rst(rst), .sleep_exec(sleep_exec), .stby_sel(stby_sel), .lowspd_sel(lowspd_sel),
    .tmode_sel(tmode_sel), .settle_sel(settle_sel), .ext_irq(ext_irq), .irq_en(irq_en),
    .cpu_mask(cpu_mask), .rst_pin_n(rst_pin_n), .osc_en(osc_en), .clk_en(clk_en), .io_hiz(io_hiz),
    .periph_prst(periph_prst), .irq_req(irq_req), .rst_req(rst_req)
  );

  function automatic int exp_settle(input int code);
    if (code > 5) return 1 << (LOGMIN + 5);
    return 1 << (LOGMIN + code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic enter_standby();
    @(negedge clk); sleep_exec = 1'b1;
    @(negedge clk); sleep_exec = 1'b0;
  endtask

  task automatic pulse_irq(input int line);
    @(negedge clk); ext_irq[line] = 1'b1;
    @(negedge clk); ext_irq[line] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for settling, counts its cycles, then checks the clock return
  task automatic measure(input int exp_n, input logic [1:0] exp_req, input int extra_line);
    int n = 0;
    int guard = 0;
    while (!(osc_en && !clk_en) && guard < 50) begin @(negedge clk); guard++; end
    while (osc_en && !clk_en && n < 2000) begin
      n++;
      if (extra_line >= 0 && n == 2) ext_irq[extra_line] = 1'b1;
      if (extra_line >= 0 && n == 3) ext_irq[extra_line] = 1'b0;
      @(negedge clk);
    end
    check(n == exp_n, "R7 settle length", n, exp_n);
    check(clk_en && !io_hiz, "R8 clocks back", {clk_en, io_hiz}, 2);
    check(irq_req == exp_req, "R8 irq_req", irq_req, exp_req);
    @(negedge clk);
    check(irq_req == 2'b00, "R8 irq_req one cycle", irq_req, 0);
  endtask

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int order [8];
    void'($urandom(32'd4242));
    idle(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1
    check(osc_en && clk_en && !io_hiz, "R1 reset run state", {osc_en, clk_en, io_hiz}, 6);
    check(!periph_prst && irq_req == 0 && !rst_req, "R1 pulses idle", {periph_prst, irq_req, rst_req}, 0);

    // R3: each blocking condition
    for (int k = 0; k < 3; k++) begin
      stby_sel = (k != 0); lowspd_sel = (k == 1); tmode_sel = (k == 2);
      enter_standby(); idle(2);
      check(osc_en && clk_en && !io_hiz, "R3 sleep ignored", {osc_en, clk_en, io_hiz}, 6);
    end
    stby_sel = 1'b1; lowspd_sel = 1'b0; tmode_sel = 1'b0;

    // R2, R4, R5
    settle_sel = 3'd1;
    enter_standby();
    check(!osc_en && !clk_en && io_hiz, "R2 standby entered", {osc_en, clk_en, io_hiz}, 1);
    check(periph_prst, "R5 partial reset pulse", periph_prst, 1);
    @(negedge clk);
    check(!periph_prst, "R5 pulse ends", periph_prst, 0);

    // R6: disabled line and masked line stay in standby
    irq_en = 2'b01;
    pulse_irq(1); idle(20);
    check(!osc_en && io_hiz, "R6 disabled line ignored", osc_en, 0);
    cpu_mask = 1'b1;
    pulse_irq(0); idle(20);
    check(!osc_en && io_hiz, "R6 masked line ignored", osc_en, 0);
    @(negedge clk); cpu_mask = 1'b0;
    measure(exp_settle(1), 2'b01, -1);

    // R7, R8: every code in random order
    irq_en = 2'b11;
    for (int i = 0; i < 8; i++) order[i] = i;
    for (int i = 7; i > 0; i--) begin
      int j = int'($urandom_range(i, 0));
      int t = order[i]; order[i] = order[j]; order[j] = t;
    end
    for (int i = 0; i < 8; i++) begin
      int line = int'($urandom_range(1, 0));
      bit extra = (i % 2 == 1);
      settle_sel = 3'(order[i]);
      enter_standby();
      check(io_hiz && !clk_en, "R4 float in standby", io_hiz, 1);
      pulse_irq(line);
      measure(exp_settle(order[i]), extra ? 2'b11 : 2'(1 << line), extra ? 1 - line : -1);
      idle(int'($urandom_range(4, 1)));
    end

    // R9, R10: abort during settling
    settle_sel = 3'd5;
    enter_standby();
    pulse_irq(0);
    idle(8);
    check(osc_en && !clk_en, "R9 in settling before abort", {osc_en, clk_en}, 2);
    rst_pin_n = 1'b0;
    idle(3);
    check(osc_en && clk_en && io_hiz, "R9 reset hold", {osc_en, clk_en, io_hiz}, 7);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq_req != 0 || !clk_en) begin
        check(0, "R9 settling aborted", {irq_req, clk_en}, 1);
        break;
      end
    end
    check(io_hiz && clk_en, "R9 still holding", io_hiz, 1);
    rst_pin_n = 1'b1;
    begin
      int g = 0;
      while (io_hiz && g < 20) begin @(negedge clk); g++; end
    end
    check(rst_req && irq_req == 0, "R10 reset request", rst_req, 1);
    @(negedge clk);
    check(!rst_req, "R10 reset request one cycle", rst_req, 0);

    // R11: pin and interrupt arrive together
    enter_standby();
    @(negedge clk); ext_irq[1] = 1'b1; rst_pin_n = 1'b0;
    @(negedge clk); ext_irq[1] = 1'b0;
    begin
      bit saw = 0;
      for (int i = 0; i < 10; i++) begin
        if (osc_en && !clk_en) saw = 1;
        @(negedge clk);
      end
      check(!saw, "R11 no settling cycle", saw, 0);
    end
    check(osc_en && clk_en && io_hiz, "R11 reset hold wins", {osc_en, clk_en, io_hiz}, 7);
    rst_pin_n = 1'b1; idle(5);
    check(!io_hiz && clk_en, "R10 running after pin release", io_hiz, 0);

    // R9 from running state
    @(negedge clk); rst_pin_n = 1'b0;
    idle(3);
    check(io_hiz && clk_en && osc_en, "R9 pin low while running", io_hiz, 1);
    rst_pin_n = 1'b1; idle(5);
    check(!io_hiz, "R10 released", io_hiz, 0);

    done = 1;
    finish_run();
  end
endmodule